// File: doc/BRIEF.md
# Three-Channel Doorbell Interrupt Unit

This block lets one processor signal another through doorbell bits held in registers. It has three channels, each with its own 32-bit pending word and its own interrupt line. The first is a low-priority non-secure channel, the second a high-priority non-secure channel, and the third a secure channel. A sender rings a doorbell by writing ones to a channel's set register. The receiver reads the channel's status register to find which events are pending, then writes ones to the clear register to acknowledge them. Any number of senders can raise different bits, one write after another, without locking, because set writes only add bits to the word.

Each channel's interrupt is the OR of its 32 pending bits. The interrupt is registered, so it follows the pending word one clock later. Each bit can therefore stand for a separate event type while all of them share one interrupt line. Register access uses an APB-style setup/access bus with a qualifier that marks an access as non-secure. A non-secure access to the secure channel is blocked and answered with an error.

Top module: `dbell_mailbox`

## Requirements
- R1: After synchronous reset, every status word is 0 and all three interrupt outputs are 0.
- R2: A write to a channel's set register (window offset 0x08) ORs the written data into that channel's status word. Zero data bits leave status bits unchanged, so successive set writes accumulate (0x800 then 0x400 gives 0xC00).
- R3: A write to a channel's clear register (window offset 0x10) clears every status bit written as 1 and leaves bits written as 0 unchanged.
- R4: A read of window offset 0x00 returns the channel's status word. Reads of the set or clear offsets return 0. Writes to offset 0x00 have no effect.
- R5: Interrupt bit c goes to 1 exactly one clock after channel c's status word becomes nonzero. It goes to 0 exactly one clock after the word becomes zero.
- R6: The channels are independent. Channel c's window starts at address c*0x20 (channel 0 low-priority, 1 high-priority, 2 secure), and an access to one channel never changes another.
- R7: An access with `ns_access`=1 to the secure channel (addresses 0x40–0x5F) reads 0, has no effect on writes, and drives `slv_err`=1 in its access phase. A secure access (`ns_access`=0) to that channel works normally.
- R8: `slv_err` is 0 for every other access, including addresses outside the three windows. Those addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Slave select (setup and access phase) |
| bus_enable | input | 1 | Access phase marker |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| ns_access | input | 1 | 1 = access comes from non-secure software |
| bus_rdata | output | 32 | Read data, valid in the access phase |
| slv_err | output | 1 | Error response in the access phase |
| irq | output | 3 | Per-channel interrupt, bit c for channel c |

## Verification
The assertions assume bus traffic follows the two-phase protocol: an access phase is always preceded by a setup phase with the same address, and at most one access completes per clock. A set and a clear therefore never reach the same channel in the same cycle. The bench drives every access through one task that produces exactly that setup-then-access sequence on falling edges and deselects the bus between accesses. It holds reset for several cycles before the first access, so every past-value check starts from the reset state.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

    // Byte width of one channel register window (0x20)
    localparam int WIN_W = 5;

    localparam logic [WIN_W-1:0] OFS_STATUS = 5'h00;
    localparam logic [WIN_W-1:0] OFS_SET    = 5'h08;
    localparam logic [WIN_W-1:0] OFS_CLEAR  = 5'h10;

    typedef enum logic [1:0] {
        RK_NONE,
        RK_STATUS,
        RK_SET,
        RK_CLEAR
    } reg_kind_e;

    typedef struct packed {
        logic      access;   // access phase in progress
        logic      in_range; // address lands in a channel window
        logic      blocked;  // non-secure access aimed at the secure channel
        reg_kind_e kind;
    } bus_dec_t;

    function automatic reg_kind_e kind_of(input logic [WIN_W-1:0] ofs);
        case (ofs)
            OFS_STATUS: return RK_STATUS;
            OFS_SET:    return RK_SET;
            OFS_CLEAR:  return RK_CLEAR;
            default:    return RK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dbell_channel.sv
module dbell_channel #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [DATA_W-1:0] set_data,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] clr_data,
    output logic [DATA_W-1:0] status,
    output logic              irq
);

    logic [DATA_W-1:0] set_mask;
    logic [DATA_W-1:0] clr_mask;
    logic [DATA_W-1:0] status_nxt;

    always_comb begin
        set_mask   = set_en ? set_data : '0;
        clr_mask   = clr_en ? clr_data : '0;
        // set has priority over clear so a ringing event is never dropped
        status_nxt = (status & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            irq    <= 1'b0;
        end else begin
            status <= status_nxt;
            irq    <= |status;
        end
    end

    // R2: every bit rung is pending on the next cycle
    a_r2_set_lands: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((status & $past(set_data)) == $past(set_data)));

    // R3: a clear without a simultaneous set removes the written bits
    a_r3_clear_lands: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !set_en) |=> ((status & $past(clr_data)) == '0));

    // R4, R6: no strobe, no change
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_en && !clr_en) |=> $stable(status));

    // R5: a nonzero ring raises the interrupt two edges later
    a_r5_raise: assert property (@(posedge clk) disable iff (rst)
        (set_en && (|set_data)) |=> ##1 irq);

    // R5: a word idle at zero keeps the interrupt low
    a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
        ((status == '0) && ($past(status) == '0)) |-> !irq);

endmodule

// File: rtl/dbell_decode.sv
module dbell_decode
    import dbell_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_CH   = 3
) (
    input  logic              bus_sel,
    input  logic              bus_enable,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              ns_access,
    input  logic [DATA_W-1:0] stat_in [N_CH],
    output logic [N_CH-1:0]   set_en,
    output logic [N_CH-1:0]   clr_en,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              slv_err
);

    localparam int CHSEL_W = ADDR_W - WIN_W;
    localparam int SEC_CH  = N_CH - 1;

    logic [CHSEL_W-1:0] ch_idx;
    bus_dec_t           dec;
    logic [N_CH-1:0]    ch_hit;

    assign ch_idx = bus_addr[ADDR_W-1:WIN_W];

    always_comb begin
        dec.access   = bus_sel && bus_enable;
        dec.in_range = (ch_idx < CHSEL_W'(N_CH));
        dec.blocked  = dec.in_range && (ch_idx == CHSEL_W'(SEC_CH)) && ns_access;
        dec.kind     = kind_of(bus_addr[WIN_W-1:0]);
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_strobe
        assign ch_hit[c] = dec.access && (ch_idx == CHSEL_W'(c)) && !dec.blocked;
        assign set_en[c] = ch_hit[c] && bus_write && (dec.kind == RK_SET);
        assign clr_en[c] = ch_hit[c] && bus_write && (dec.kind == RK_CLEAR);
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < N_CH; c++) begin
            if (ch_hit[c] && !bus_write && (dec.kind == RK_STATUS))
                bus_rdata = stat_in[c];
        end
    end

    assign slv_err = dec.access && dec.blocked;

    // R6: at most one channel strobed per access
    always_comb begin
        a_r6_one_target: assert ($onehot0(set_en | clr_en));
    end

endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
    import dbell_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int N_CH   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_enable,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ns_access,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              slv_err,
    output logic [N_CH-1:0]   irq
);

    localparam int CHSEL_W = ADDR_W - WIN_W;
    localparam int SEC_CH  = N_CH - 1;

    logic [N_CH-1:0]   set_en;
    logic [N_CH-1:0]   clr_en;
    logic [DATA_W-1:0] stat_w [N_CH];

    dbell_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_CH   (N_CH)
    ) u_decode (
        .bus_sel    (bus_sel),
        .bus_enable (bus_enable),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .ns_access  (ns_access),
        .stat_in    (stat_w),
        .set_en     (set_en),
        .clr_en     (clr_en),
        .bus_rdata  (bus_rdata),
        .slv_err    (slv_err)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        dbell_channel #(
            .DATA_W (DATA_W)
        ) u_ch (
            .clk      (clk),
            .rst      (rst),
            .set_en   (set_en[c]),
            .set_data (bus_wdata),
            .clr_en   (clr_en[c]),
            .clr_data (bus_wdata),
            .status   (stat_w[c]),
            .irq      (irq[c])
        );
    end

    logic ns_to_secure;
    assign ns_to_secure = bus_sel && bus_enable && ns_access &&
                          (bus_addr[ADDR_W-1:WIN_W] == CHSEL_W'(SEC_CH));

    // R7: non-secure access to the secure window is answered with an error
    a_r7_err: assert property (@(posedge clk) disable iff (rst)
        ns_to_secure |-> slv_err);

    // R7: and leaves the secure word untouched
    a_r7_sealed: assert property (@(posedge clk) disable iff (rst)
        ns_to_secure |=> $stable(stat_w[SEC_CH]));

    // R8: an error only ever answers a non-secure access phase
    a_r8_err_only: assert property (@(posedge clk) disable iff (rst)
        slv_err |-> (bus_sel && bus_enable && ns_access));

endmodule

// File: tb/dbell_mailbox_bench.sv
module dbell_mailbox_bench;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int N_CH   = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_enable = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              ns_access = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              slv_err;
    logic [N_CH-1:0]   irq;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk; // 125 MHz

    dbell_mailbox #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .N_CH   (N_CH)
    ) u_dbell_mailbox (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_enable (bus_enable),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .ns_access  (ns_access),
        .bus_rdata  (bus_rdata),
        .slv_err    (slv_err),
        .irq        (irq)
    );

    // vector: {ns, write, addr[7:0], data[31:0], exp_err, exp_rdata[31:0]}
    localparam int VW = 1 + 1 + 8 + 32 + 1 + 32;
    localparam int NV = 21;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 1'b1, 8'h08, 32'h0000_0800, 1'b0, 32'h0},           // R2 ring bit 11
        {1'b0, 1'b1, 8'h08, 32'h0000_0400, 1'b0, 32'h0},           // R2 ring bit 10
        {1'b0, 1'b0, 8'h00, 32'h0,         1'b0, 32'h0000_0C00},   // R2 both pending
        {1'b0, 1'b1, 8'h10, 32'h0000_0400, 1'b0, 32'h0},           // R3 ack bit 10
        {1'b0, 1'b0, 8'h00, 32'h0,         1'b0, 32'h0000_0800},   // R3
        {1'b0, 1'b1, 8'h28, 32'hFFFF_0000, 1'b0, 32'h0},           // R6 ring ch1
        {1'b0, 1'b0, 8'h20, 32'h0,         1'b0, 32'hFFFF_0000},   // R6
        {1'b0, 1'b0, 8'h00, 32'h0,         1'b0, 32'h0000_0800},   // R6 ch0 untouched
        {1'b0, 1'b0, 8'h08, 32'h0,         1'b0, 32'h0},           // R4 set reg reads 0
        {1'b0, 1'b1, 8'h00, 32'hFFFF_FFFF, 1'b0, 32'h0},           // R4 status write ignored
        {1'b0, 1'b0, 8'h00, 32'h0,         1'b0, 32'h0000_0800},   // R4
        {1'b1, 1'b1, 8'h48, 32'h0000_0001, 1'b1, 32'h0},           // R7 ns ring blocked
        {1'b0, 1'b0, 8'h40, 32'h0,         1'b0, 32'h0},           // R7 secure view empty
        {1'b0, 1'b1, 8'h48, 32'h8000_0001, 1'b0, 32'h0},           // R7 secure ring
        {1'b1, 1'b0, 8'h40, 32'h0,         1'b1, 32'h0},           // R7 ns read zero
        {1'b0, 1'b0, 8'h40, 32'h0,         1'b0, 32'h8000_0001},   // R7
        {1'b1, 1'b1, 8'h50, 32'hFFFF_FFFF, 1'b1, 32'h0},           // R7 ns clear blocked
        {1'b0, 1'b0, 8'h40, 32'h0,         1'b0, 32'h8000_0001},   // R7
        {1'b0, 1'b1, 8'h30, 32'h0,         1'b0, 32'h0},           // R3 zero clear
        {1'b0, 1'b0, 8'h20, 32'h0,         1'b0, 32'hFFFF_0000},   // R3
        {1'b1, 1'b0, 8'h60, 32'h0,         1'b0, 32'h0}            // R8 unmapped
    };

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // setup phase, access phase (sampled before its rising edge), idle
    task automatic bus_op(input logic ns, input logic wr, input logic [7:0] a,
                          input logic [31:0] d, output logic [31:0] rd,
                          output logic err);
        @(negedge clk);
        bus_sel = 1'b1; bus_enable = 1'b0; bus_write = wr;
        bus_addr = a; bus_wdata = d; ns_access = ns;
        @(negedge clk);
        bus_enable = 1'b1;
        #1;
        rd = bus_rdata;
        err = slv_err;
        @(negedge clk);
        bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        err;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 irq", {29'b0, irq}, 32'h0);
        rst = 1'b0;
        for (int c = 0; c < N_CH; c++) begin
            bus_op(1'b0, 1'b0, 8'(c * 32), 32'h0, rd, err);
            check("R1 status", rd, 32'h0);
        end

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            bus_op(v[74], v[73], v[72:65], v[64:33], rd, err);
            check("R8 vec err", {31'b0, err}, {31'b0, v[32]});
            if (!v[73]) check("R2-R7 vec rdata", rd, v[31:0]);
        end

        // R5: all three words pending
        check("R5 all raised", {29'b0, irq}, 32'h7);

        // R5: clear ch0; irq drops one clock after the word empties
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 8'h10;
        bus_wdata = 32'hFFFF_FFFF; ns_access = 1'b0;
        @(negedge clk);
        bus_enable = 1'b1;
        @(negedge clk); // word cleared at the edge just passed
        bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
        #1;
        check("R5 irq lag", {29'b0, irq}, 32'h7);
        @(negedge clk);
        #1;
        check("R5 irq fall", {29'b0, irq}, 32'h6);

        // R5: ring ch0 again; rise one clock after the word changes
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h1;
        @(negedge clk);
        bus_enable = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
        #1;
        check("R5 rise lag", {29'b0, irq}, 32'h6);
        @(negedge clk);
        #1;
        check("R5 irq rise", {29'b0, irq}, 32'h7);

        // R1: reset mid-run empties everything
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 irq after reset", {29'b0, irq}, 32'h0);
        rst = 1'b0;
        bus_op(1'b0, 1'b0, 8'h40, 32'h0, rd, err);
        check("R1 secure status after reset", rd, 32'h0);
        bus_op(1'b0, 1'b0, 8'h20, 32'h0, rd, err);
        check("R1 ch1 status after reset", rd, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule